// File: doc/BRIEF.md
# TDM Transmit Slot-Mask Controller

This block is the transmit half of a network-mode time-division-multiplexed serial port with one data lane. An internal frame counter divides time into frames of `SLOTS` slots, each `WORD_W` bit periods long. At the first bit of every slot the holding register is copied into the shift register, which then shifts the word out MSB first. A per-slot enable mask decides whether the line is driven in that slot. It also decides whether the slot raises the transmit-empty flag, the empty interrupt pulse and the underrun flag.

Software loads a 32-bit mask as two 16-bit halves. The mask is copied into a working shadow only when a new frame begins, so the frame in progress keeps its pattern. A write to the skip register turns the driver off for the next slot only. In a masked slot the transfer still happens but raises no flag. A word written after an interrupt therefore goes out in the next enabled slot. When an enabled slot starts before any new word has been written, the previous word is sent again and the underrun flag is set.

Top module: `tdm_tx_slotmask`

## Requirements
- R1: After reset both mask halves read 0xFFFF, `tx_oe`, `empty_flag`, `underrun_flag` and `empty_irq` are 0, and every slot of the first frame is driven.
- R2: Register address 0 holds mask bits 15:0 and address 1 holds bits 31:16. Mask bit n enables slot n, and bits at or above `SLOTS` have no effect on the line.
- R3: For the whole of a disabled slot `tx_oe` is 0 and `tx_sd` is 0. For the whole of an enabled slot `tx_oe` is 1 and the word is shifted out MSB first, one bit per bit period.
- R4: The holding register (address 2, low `WORD_W` bits) is copied to the shift register at the start of every slot. A masked slot sets no flag, and a word written after an interrupt is sent in the next enabled slot, with masked slots in between.
- R5: The start of an enabled slot sets `empty_flag` and pulses `empty_irq` for one clock. The start of a masked slot does neither.
- R6: A write to address 2 clears `empty_flag`, unless an enabled slot starts in the same cycle.
- R7: When an enabled slot starts and address 2 has not been written since the last enabled-slot transfer, `underrun_flag` is set and the previous word is sent again. Any write to address 4 clears `underrun_flag`, and masked slots never set it.
- R8: Any write to address 3 forces `tx_oe` low for the next slot to start, even if that slot is enabled. Flags in that slot still follow the mask, and the slot after it behaves normally again.
- R9: A mask write takes effect from the next slot 0. The frame in progress keeps the mask it started with.
- R10: Reading addresses 0 and 1 on `reg_rdata` returns the value last written, not the shadow in use.
- R11: `fsync` is high only during the first bit period of slot 0, `slot_num` gives the slot being sent, and a frame lasts `SLOTS*WORD_W` bit periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for writes and reads |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Mask half selected by `reg_addr` (0 for other addresses) |
| tx_sd | output | 1 | Serial data, 0 when not driven |
| tx_oe | output | 1 | Output enable for the serial data line |
| fsync | output | 1 | Frame sync, first bit period of slot 0 |
| slot_num | output | $clog2(SLOTS) | Slot currently being sent |
| empty_flag | output | 1 | Transmit holding register empty |
| underrun_flag | output | 1 | Sticky underrun indication |
| empty_irq | output | 1 | One-clock empty interrupt pulse |

## Verification
The hardest situation to reach is a run of masked slots between a serviced interrupt and the next enabled slot. Several things must be seen together there: the written word waits, no flag is raised inside the gap, and only the first enabled slot after the gap is free of underrun. The bench loads a mask with a gap of three slots and waits two frame boundaries so the shadow holds it. It then writes a new word and clears underrun inside slot 0 at fixed bit positions, and samples the flags at the last bit before the gap ends, at the first enabled bit after it, and one slot later. Shadowing is checked by writing each table mask in the middle of a frame and comparing the two frames that follow.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

   typedef enum logic [2:0] {
      ADDR_MASK_LO = 3'd0,
      ADDR_MASK_HI = 3'd1,
      ADDR_HOLD    = 3'd2,
      ADDR_SKIP    = 3'd3,
      ADDR_UR_CLR  = 3'd4
   } tx_addr_e;

   localparam int HALF_W = 16;
   localparam int MASK_W = 32;

endpackage

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr #(
   parameter int SLOTS   = 8,
   parameter int WORD_W  = 8,
   parameter int CLK_DIV = 1,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              tick,
   output logic              slot_start,
   output logic              frame_start,
   output logic [SLOT_W-1:0] slot_idx,
   output logic [SLOT_W-1:0] next_slot,
   output logic              fsync
);

   localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

   logic [BIT_W-1:0] bit_idx;

   // bit-period strobe: every clock, or every CLK_DIV clocks
   generate
      if (CLK_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DIV_W = $clog2(CLK_DIV);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
         logic [DIV_W-1:0] div_cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)               div_cnt <= '0;
            else if (div_cnt == DIV_LAST) div_cnt <= '0;
            else                      div_cnt <= div_cnt + DIV_W'(1);
         end
         assign tick = (div_cnt == DIV_LAST);
      end
   endgenerate

   assign slot_start  = tick && (bit_idx == LAST_BIT);
   assign frame_start = slot_start && (slot_idx == LAST_SLOT);
   assign next_slot   = (slot_idx == LAST_SLOT) ? '0 : slot_idx + SLOT_W'(1);

   // counters reset to the last bit of the last slot, so the first
   // strobe after reset opens slot 0 of frame one
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_idx  <= LAST_BIT;
         slot_idx <= LAST_SLOT;
      end else if (tick) begin
         if (bit_idx == LAST_BIT) begin
            bit_idx  <= '0;
            slot_idx <= next_slot;
         end else begin
            bit_idx <= bit_idx + BIT_W'(1);
         end
      end
   end

   assign fsync = (slot_idx == '0) && (bit_idx == '0);

endmodule

// File: rtl/tdm_mask_regs.sv
module tdm_mask_regs
   import tdm_tx_pkg::*;
#(
   parameter int SLOTS = 8,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [HALF_W-1:0] reg_wdata,
   input  logic              slot_start,
   input  logic              frame_start,
   input  logic [SLOT_W-1:0] next_slot,
   output logic [HALF_W-1:0] reg_rdata,
   output logic              slot_en,
   output logic              skip_now
);

   logic [HALF_W-1:0] half_q [2];
   logic [MASK_W-1:0] mask_all;
   logic [SLOTS-1:0]  shadow_q;
   logic [SLOTS-1:0]  mask_eff;
   logic              skip_q;
   logic              skip_wr;

   // two software-visible halves, each reset to all ones
   generate
      for (genvar h = 0; h < 2; h++) begin : g_half
         localparam logic [2:0] MY_ADDR = (h == 0) ? ADDR_MASK_LO : ADDR_MASK_HI;
         always_ff @(posedge clk) begin
            if (!rst_n)                             half_q[h] <= '1;
            else if (reg_wr && reg_addr == MY_ADDR) half_q[h] <= reg_wdata;
         end
      end
   endgenerate

   assign mask_all = {half_q[1], half_q[0]};

   // shadow is refreshed as slot 0 opens; slot 0 itself already sees the new mask
   always_ff @(posedge clk) begin
      if (!rst_n)           shadow_q <= '1;
      else if (frame_start) shadow_q <= mask_all[SLOTS-1:0];
   end

   assign mask_eff = frame_start ? mask_all[SLOTS-1:0] : shadow_q;
   assign slot_en  = mask_eff[next_slot];

   // one-shot skip: armed by a write, spent by the next slot start
   assign skip_wr = reg_wr && (reg_addr == ADDR_SKIP);

   always_ff @(posedge clk) begin
      if (!rst_n)          skip_q <= 1'b0;
      else if (skip_wr)    skip_q <= 1'b1;
      else if (slot_start) skip_q <= 1'b0;
   end

   assign skip_now = skip_q;

   always_comb begin
      case (reg_addr)
         ADDR_MASK_LO: reg_rdata = half_q[0];
         ADDR_MASK_HI: reg_rdata = half_q[1];
         default:      reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/tdm_tx_datapath.sv
module tdm_tx_datapath #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              slot_start,
   input  logic              slot_en,
   input  logic              skip_now,
   input  logic              hold_wr,
   input  logic              ur_clr,
   input  logic [WORD_W-1:0] hold_wdata,
   output logic              tx_sd,
   output logic              tx_oe,
   output logic              empty_flag,
   output logic              underrun_flag,
   output logic              empty_irq
);

   logic [WORD_W-1:0] hold_q;
   logic [WORD_W-1:0] shift_q;
   logic              fresh_q;
   logic              oe_q;
   logic              live_start;

   assign live_start = slot_start && slot_en;

   always_ff @(posedge clk) begin
      if (!rst_n)       hold_q <= '0;
      else if (hold_wr) hold_q <= hold_wdata;
   end

   // transfer happens every slot, enabled or not
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q <= '0;
         oe_q    <= 1'b0;
      end else if (slot_start) begin
         shift_q <= hold_q;
         oe_q    <= slot_en && !skip_now;
      end else if (tick) begin
         shift_q <= {shift_q[WORD_W-2:0], 1'b0};
      end
   end

   // fresh: a word has been written since the last enabled transfer
   always_ff @(posedge clk) begin
      if (!rst_n)          fresh_q <= 1'b0;
      else if (hold_wr)    fresh_q <= 1'b1;
      else if (live_start) fresh_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         empty_flag    <= 1'b0;
         underrun_flag <= 1'b0;
         empty_irq     <= 1'b0;
      end else begin
         empty_irq <= live_start;
         if (live_start)   empty_flag <= 1'b1;
         else if (hold_wr) empty_flag <= 1'b0;
         if (live_start && !fresh_q) underrun_flag <= 1'b1;
         else if (ur_clr)            underrun_flag <= 1'b0;
      end
   end

   assign tx_oe = oe_q;
   assign tx_sd = oe_q & shift_q[WORD_W-1];

endmodule

// File: rtl/tdm_tx_slotmask.sv
module tdm_tx_slotmask
   import tdm_tx_pkg::*;
#(
   parameter int SLOTS   = 8,
   parameter int WORD_W  = 8,
   parameter int CLK_DIV = 1,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   output logic              tx_sd,
   output logic              tx_oe,
   output logic              fsync,
   output logic [SLOT_W-1:0] slot_num,
   output logic              empty_flag,
   output logic              underrun_flag,
   output logic              empty_irq
);

   generate
      if (SLOTS < 2 || SLOTS > MASK_W) begin : g_bad_slots
         $error("SLOTS must lie in 2..32");
      end
      if (WORD_W < 2 || WORD_W > HALF_W) begin : g_bad_word
         $error("WORD_W must lie in 2..16");
      end
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
   endgenerate

   logic              tick;
   logic              slot_start;
   logic              frame_start;
   logic [SLOT_W-1:0] next_slot;
   logic              slot_en;
   logic              skip_now;
   logic              hold_wr;
   logic              ur_clr;

   assign hold_wr = reg_wr && (reg_addr == ADDR_HOLD);
   assign ur_clr  = reg_wr && (reg_addr == ADDR_UR_CLR);

   tdm_frame_ctr #(
      .SLOTS(SLOTS), .WORD_W(WORD_W), .CLK_DIV(CLK_DIV)
   ) u_ctr (
      .clk(clk), .rst_n(rst_n), .tick(tick), .slot_start(slot_start),
      .frame_start(frame_start), .slot_idx(slot_num),
      .next_slot(next_slot), .fsync(fsync)
   );

   tdm_mask_regs #(.SLOTS(SLOTS)) u_mask (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .slot_start(slot_start),
      .frame_start(frame_start), .next_slot(next_slot),
      .reg_rdata(reg_rdata), .slot_en(slot_en), .skip_now(skip_now)
   );

   tdm_tx_datapath #(.WORD_W(WORD_W)) u_dp (
      .clk(clk), .rst_n(rst_n), .tick(tick), .slot_start(slot_start),
      .slot_en(slot_en), .skip_now(skip_now), .hold_wr(hold_wr),
      .ur_clr(ur_clr), .hold_wdata(reg_wdata[WORD_W-1:0]),
      .tx_sd(tx_sd), .tx_oe(tx_oe), .empty_flag(empty_flag),
      .underrun_flag(underrun_flag), .empty_irq(empty_irq)
   );

endmodule

// File: rtl/tdm_tx_slotmask_chk.sv
module tdm_tx_slotmask_chk
   import tdm_tx_pkg::*;
#(
   parameter int SLOTS = 8,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [2:0]        reg_addr,
   input logic              tx_sd,
   input logic              tx_oe,
   input logic              fsync,
   input logic [SLOT_W-1:0] slot_num,
   input logic              empty_flag,
   input logic              underrun_flag,
   input logic              empty_irq
);

   AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_oe |-> !tx_sd);  // R3

   AST_OE_HELD_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(slot_num) |-> $stable(tx_oe));  // R3

   AST_IRQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      empty_irq |=> !empty_irq);  // R5

   AST_IRQ_WITH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      empty_irq |-> empty_flag);  // R5

   AST_HOLD_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_HOLD) |=> (empty_irq || !empty_flag));  // R6

   AST_UNDERRUN_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underrun_flag) |-> empty_irq);  // R7

   AST_FSYNC_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |-> (slot_num == '0));  // R11

endmodule

bind tdm_tx_slotmask tdm_tx_slotmask_chk #(.SLOTS(SLOTS)) u_chk (.*);

// File: tb/sim_tdm_tx_slotmask.sv
module sim_tdm_tx_slotmask;

   localparam int NS = 8;
   localparam int W  = 8;
   localparam int FRAME = NS * W;
   localparam logic [7:0] HOLD_A = 8'hC3;
   localparam logic [7:0] HOLD_B = 8'h5A;

   // {mask low half, mask high half, expected enabled-slot pattern}
   localparam logic [39:0] VEC [7] = '{
      {16'hFFFF, 16'hFFFF, 8'hFF},
      {16'h00FF, 16'h0000, 8'hFF},
      {16'hFF00, 16'hFFFF, 8'h00},
      {16'h0055, 16'h0000, 8'h55},
      {16'h00AA, 16'h1234, 8'hAA},
      {16'h0081, 16'h0000, 8'h81},
      {16'h007E, 16'h0000, 8'h7E}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        tx_sd, tx_oe, fsync, empty_flag, underrun_flag, empty_irq;
   logic [2:0]  slot_num;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   tdm_tx_slotmask #(.SLOTS(NS), .WORD_W(W), .CLK_DIV(1)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_sd(tx_sd),
      .tx_oe(tx_oe), .fsync(fsync), .slot_num(slot_num),
      .empty_flag(empty_flag), .underrun_flag(underrun_flag),
      .empty_irq(empty_irq)
   );

   // line monitor: collects one frame of observations per slot
   int pos = -1;
   int cur_pos = -1;
   int frame_no = 0;
   int glitch = 0;
   int last_len = 0;
   logic [7:0]   cur_oe, cur_irq, done_oe, done_irq;
   logic [W-1:0] cur_word [NS];
   logic [W-1:0] done_word [NS];

   always @(negedge clk) begin
      if (!rst_n) begin
         pos = -1;
         cur_pos = -1;
      end else begin
         if (fsync) begin
            if (pos >= 0) begin
               last_len  = pos;
               done_oe   = cur_oe;
               done_irq  = cur_irq;
               done_word = cur_word;
               frame_no++;
            end
            pos = 0;
         end
         if (pos >= 0) begin
            if (pos % W == 0) begin
               cur_oe[pos / W]   = tx_oe;
               cur_irq[pos / W]  = empty_irq;
               cur_word[pos / W] = '0;
            end else if (tx_oe !== cur_oe[pos / W] || empty_irq) begin
               glitch++;
            end
            cur_word[pos / W] = {cur_word[pos / W][W-2:0], tx_sd};
            cur_pos = pos;
            pos++;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [2:0] a, input logic [15:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic wait_frames(input int n);
      int t;
      t = frame_no;
      wait (frame_no == t + n);
   endtask

   function automatic int word_miss(input logic [7:0] en, input logic [W-1:0] w);
      int m = 0;
      for (int s = 0; s < NS; s++)
         if (en[s] && done_word[s] !== w) m++;
      return m;
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] prev_exp;
      repeat (3) @(negedge clk);
      // R1 reset state
      reg_addr = 3'd0; #1;
      chk("R1 mask low after reset", {16'h0, reg_rdata}, 32'hFFFF);
      reg_addr = 3'd1; #1;
      chk("R1 mask high after reset", {16'h0, reg_rdata}, 32'hFFFF);
      chk("R1 outputs idle in reset",
          {28'h0, tx_oe, empty_flag, underrun_flag, empty_irq}, 32'h0);
      rst_n = 1'b1;
      do_write(3'd2, {8'h0, HOLD_A});
      wait (frame_no == 1);
      chk("R1 first frame all slots on", {24'h0, done_oe}, 32'hFF);
      chk("R11 frame length", last_len, FRAME);
      prev_exp = 8'hFF;

      // table of masks, each written mid-frame
      for (int i = 0; i < 7; i++) begin
         wait (cur_pos == 2 * W + 3);
         do_write(3'd0, VEC[i][39:24]);
         do_write(3'd1, VEC[i][23:8]);
         reg_addr = 3'd0; #1;
         chk("R10 readback low", {16'h0, reg_rdata}, {16'h0, VEC[i][39:24]});
         reg_addr = 3'd1; #1;
         chk("R10 readback high", {16'h0, reg_rdata}, {16'h0, VEC[i][23:8]});
         wait_frames(1);
         chk("R9 frame in progress keeps old mask", {24'h0, done_oe}, {24'h0, prev_exp});
         wait_frames(1);
         chk("R2 new mask drives line", {24'h0, done_oe}, {24'h0, VEC[i][7:0]});
         chk("R5 irq only in enabled slots", {24'h0, done_irq}, {24'h0, VEC[i][7:0]});
         chk("R4 enabled slots carry held word", word_miss(VEC[i][7:0], HOLD_A), 0);
         prev_exp = VEC[i][7:0];
      end

      // R8 one-shot skip
      wait (cur_pos == 2 * W + 3);
      do_write(3'd0, 16'hFFFF);
      wait_frames(2);
      wait (cur_pos == 2 * W + 2);
      do_write(3'd3, 16'h0);
      wait_frames(1);
      chk("R8 skipped slot not driven", {24'h0, done_oe}, 32'hF7);
      chk("R8 skipped slot flags follow mask", {24'h0, done_irq}, 32'hFF);
      wait_frames(1);
      chk("R8 skip spent after one slot", {24'h0, done_oe}, 32'hFF);

      // gap of masked slots after a serviced interrupt
      wait (cur_pos == 3 * W);
      do_write(3'd0, 16'h00F1);
      wait_frames(2);
      chk("R5 irq at enabled slot 0", {31'h0, empty_irq}, 32'h1);
      wait (cur_pos == 2);
      do_write(3'd2, {8'h0, HOLD_B});
      do_write(3'd4, 16'h0);
      wait (cur_pos == W);
      chk("R3 masked slot not driven", {31'h0, tx_oe}, 32'h0);
      chk("R5 no irq in masked slot", {31'h0, empty_irq}, 32'h0);
      wait (cur_pos == W + 1);
      chk("R6 hold write cleared empty", {31'h0, empty_flag}, 32'h0);
      wait (cur_pos == 4 * W - 1);
      chk("R4 masked slots set no empty", {31'h0, empty_flag}, 32'h0);
      chk("R7 masked slots set no underrun", {31'h0, underrun_flag}, 32'h0);
      wait (cur_pos == 4 * W);
      chk("R5 empty set at next enabled slot", {31'h0, empty_flag}, 32'h1);
      chk("R7 fresh word gives no underrun", {31'h0, underrun_flag}, 32'h0);
      chk("R11 slot number", {29'h0, slot_num}, 32'd4);
      wait (cur_pos == 5 * W);
      chk("R7 stale word sets underrun", {31'h0, underrun_flag}, 32'h1);
      wait_frames(1);
      chk("R4 slot 0 sent old word", {24'h0, done_word[0]}, {24'h0, HOLD_A});
      chk("R4 new word waits for slot 4", {24'h0, done_word[4]}, {24'h0, HOLD_B});
      chk("R7 word resent in slot 6", {24'h0, done_word[6]}, {24'h0, HOLD_B});
      chk("R3 masked slots silent", {24'h0, done_word[1] | done_word[2] | done_word[3]}, 32'h0);
      chk("R2 gap mask pattern", {24'h0, done_oe}, 32'hF1);
      chk("R3 oe and irq steady inside slots", glitch, 0);
      chk("R11 frame length held", last_len, FRAME);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule